// File: doc/BRIEF.md
# Replica-Delay Supply Voltage Controller

This controller sets the supply-voltage code of a memory block to the lowest value at which a read still finishes in time. The completion signal of a replica read path is passed through a short chain of delay stages outside this block. Each stage output arrives on one bit of `tap_in`, and all of them are sampled on the same clock edge. A stage counts as reached only when it and every earlier stage were sampled high. The controller compares how far the transition travelled with a fixed safety-margin stage and a spare stage two positions beyond it. From that it raises, lowers or keeps a 6-bit voltage code. After every change it waits a programmable number of cycles so that the regulator can settle before it looks again.

On top of the voltage loop, a body-bias enable is raised whenever the driven code stands for less than about 0.6 V. The code is linear from 0.30 V (code 0) to 1.50 V (code 63), so codes 0 to 15 lie below 0.6 V. A standby request drives the retention code 0 (0.30 V) and puts the address decoder to sleep. On wake-up the last active code comes back at once, and the decoder stays asleep for one settle period. All pins are plain level signals sampled on `clk`. There is no streamed data, so there is no valid/ready handshake.

Top module: `dvfm_volt_ctl`

## Requirements
- R1: After reset the driven code is 63 (the highest voltage), `bias_en` is 0 and `dec_sleep` is 0.
- R2: Bit i of `tap_in` belongs to delay stage i. Stages 0 to 11 are sampled on each clock edge. The margin is met when bits 0 through 9 of that sample are all 1. If a sample that does not meet the margin is evaluated, the code rises by one on the following edge.
- R3: If bits 0 through 11 of an evaluated sample are all 1, the code falls by one on the following edge.
- R4: A sample with bits 0 to 9 all 1 and bits 0 to 11 not all 1 leaves the code unchanged, and sampling and evaluation go on every cycle.
- R5: After a code change, no evaluation happens for max(`settle_cycles`,1) cycles. The next possible change therefore comes max(`settle_cycles`,1)+1 edges after the previous one.
- R6: The active code never rises above 63 and never falls below 3 (about 0.357 V). A step that is blocked by these limits counts as no change and starts no settle wait.
- R7: `bias_en` is 1 exactly when the driven code is below 16. This includes the retention code in standby.
- R8: A high `standby_req` seen on an edge while active drives code 0 and `dec_sleep`=1 from that edge on. The active code is frozen while in standby, whatever the taps show.
- R9: When `standby_req` is seen low during standby, the frozen code is driven again at once. `dec_sleep` stays 1 for max(`settle_cycles`,1) cycles and is then released, and evaluation resumes on the edge after that.
- R10: A high `standby_req` seen during the wake-up wait goes straight back to standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_in | input | 12 | Delayed replica-completion stage outputs, bit i = stage i |
| standby_req | input | 1 | Request for retention standby, level sensitive |
| settle_cycles | input | 8 | Wait after a code change or on wake-up, in cycles (0 acts as 1) |
| vcode_o | output | 6 | Supply voltage code, 0.30 V + code x 1.2 V / 63 |
| bias_en | output | 1 | Body-bias enable for low-voltage operation |
| dec_sleep | output | 1 | Address decoder low-leakage cut-off |

## Verification
The assertions assume that `standby_req` and `settle_cycles` are synchronous to `clk`, and that the tap bits have already been captured on an edge before they influence anything. Metastability on `tap_in` is treated as absent. The bench drives every input on the falling edge, so each value is stable at the rising edge that samples it. The bench also changes `settle_cycles` in the middle of a settle wait, to show that only the value present when the wait was loaded matters. The tap patterns include clean thermometer fills and codes with bubbles in them. A bubble below the margin stage has to count as a missed margin.

// File: rtl/dvfm_ctl_pkg.sv
package dvfm_ctl_pkg;
  typedef enum logic [1:0] {
    ST_EVAL,
    ST_SETTLE,
    ST_SLEEP,
    ST_WAKE
  } ctl_state_e;

  typedef enum logic [1:0] {
    STEP_HOLD,
    STEP_UP,
    STEP_DOWN
  } step_e;
endpackage

// File: rtl/dvfm_tap_capture.sv
module dvfm_tap_capture #(
  parameter int NTAPS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTAPS-1:0] tap_in,
  output logic [NTAPS-1:0] cap_q
);
  // one sampling flop per delay stage
  for (genvar i = 0; i < NTAPS; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cap_q[i] <= 1'b0;
      else        cap_q[i] <= tap_in[i];
    end
  end
endmodule

// File: rtl/dvfm_slack_eval.sv
module dvfm_slack_eval
  import dvfm_ctl_pkg::*;
#(
  parameter int MARGIN_TAP = 9,
  parameter int SPARE_TAP  = 11
) (
  input  logic [SPARE_TAP:0] cap,
  output step_e              step
);
  // reach[i]: stages 0..i all captured, so a bubble counts as not reached
  logic [SPARE_TAP:0] reach;

  assign reach[0] = cap[0];
  for (genvar i = 1; i <= SPARE_TAP; i++) begin : g_reach
    assign reach[i] = reach[i-1] & cap[i];
  end

  always_comb begin
    if (!reach[MARGIN_TAP])    step = STEP_UP;
    else if (reach[SPARE_TAP]) step = STEP_DOWN;
    else                       step = STEP_HOLD;
  end
endmodule

// File: rtl/dvfm_step_fsm.sv
module dvfm_step_fsm
  import dvfm_ctl_pkg::*;
#(
  parameter int VW       = 6,
  parameter int SW       = 8,
  parameter int CODE_MIN = 3,
  parameter int CODE_MAX = 63
) (
  input  logic          clk,
  input  logic          rst_n,
  input  step_e         step,
  input  logic          standby_req,
  input  logic [SW-1:0] settle_cycles,
  output logic [VW-1:0] code_q,
  output ctl_state_e    state_q
);
  localparam logic [VW-1:0] LO_C  = VW'(CODE_MIN);
  localparam logic [VW-1:0] HI_C  = VW'(CODE_MAX);
  localparam logic [SW-1:0] ONE_C = SW'(1);

  logic [SW-1:0] cnt_q, cnt_d;
  logic [VW-1:0] code_d, stepped;
  ctl_state_e    state_d;

  always_comb begin
    stepped = code_q;
    case (step)
      STEP_UP:   if (code_q < HI_C) stepped = code_q + 1'b1;
      STEP_DOWN: if (code_q > LO_C) stepped = code_q - 1'b1;
      default:   stepped = code_q;
    endcase
  end

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_EVAL: begin
        if (standby_req) begin
          state_d = ST_SLEEP;
        end else if (stepped != code_q) begin
          code_d  = stepped;
          cnt_d   = settle_cycles;
          state_d = ST_SETTLE;
        end
      end
      ST_SETTLE, ST_WAKE: begin
        if (standby_req)         state_d = ST_SLEEP;
        else if (cnt_q <= ONE_C) state_d = ST_EVAL;
        else                     cnt_d   = cnt_q - 1'b1;
      end
      ST_SLEEP: begin
        if (!standby_req) begin
          state_d = ST_WAKE;
          cnt_d   = settle_cycles;
        end
      end
      default: state_d = ST_EVAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_EVAL;
      code_q  <= HI_C;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/dvfm_volt_ctl.sv
module dvfm_volt_ctl
  import dvfm_ctl_pkg::*;
#(
  parameter int MARGIN_TAP = 9,
  parameter int SPARE_GAP  = 2,
  parameter int VW         = 6,
  parameter int SW         = 8,
  parameter int CODE_MIN   = 3,
  parameter int CODE_MAX   = 63,
  parameter int RET_CODE   = 0,
  parameter int BIAS_BELOW = 16,
  localparam int SPARE_TAP = MARGIN_TAP + SPARE_GAP,
  localparam int NTAPS     = SPARE_TAP + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTAPS-1:0] tap_in,
  input  logic             standby_req,
  input  logic [SW-1:0]    settle_cycles,
  output logic [VW-1:0]    vcode_o,
  output logic             bias_en,
  output logic             dec_sleep
);
  logic [NTAPS-1:0] cap_q;
  step_e            step;
  logic [VW-1:0]    code_q;
  ctl_state_e       state_q;

  dvfm_tap_capture #(.NTAPS(NTAPS)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .tap_in (tap_in),
    .cap_q  (cap_q)
  );

  dvfm_slack_eval #(.MARGIN_TAP(MARGIN_TAP), .SPARE_TAP(SPARE_TAP)) u_eval (
    .cap  (cap_q),
    .step (step)
  );

  dvfm_step_fsm #(
    .VW(VW), .SW(SW), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .step          (step),
    .standby_req   (standby_req),
    .settle_cycles (settle_cycles),
    .code_q        (code_q),
    .state_q       (state_q)
  );

  assign vcode_o   = (state_q == ST_SLEEP) ? VW'(RET_CODE) : code_q;
  assign dec_sleep = (state_q == ST_SLEEP) || (state_q == ST_WAKE);
  assign bias_en   = (vcode_o < VW'(BIAS_BELOW));
endmodule

// File: rtl/dvfm_volt_ctl_chk.sv
module dvfm_volt_ctl_chk #(
  parameter int VW       = 6,
  parameter int CODE_MIN = 3,
  parameter int RET_CODE = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          standby_req,
  input logic [VW-1:0] vcode_o,
  input logic          bias_en,
  input logic          dec_sleep
);
  // R2/R3: an active change is always a single step
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_sleep && !$past(dec_sleep) && vcode_o != $past(vcode_o))
      |-> (vcode_o == $past(vcode_o) + 1'b1 || vcode_o == $past(vcode_o) - 1'b1));

  // R6: active code stays at or above the floor
  a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_sleep |-> vcode_o >= VW'(CODE_MIN));

  // R5: no change on the edge right after a change
  a_r5_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_sleep && !$past(dec_sleep) && vcode_o != $past(vcode_o))
      |=> (dec_sleep || $stable(vcode_o)));

  // R8: standby request forces retention code and decoder sleep
  a_r8_standby_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_req && !dec_sleep) |=> (dec_sleep && vcode_o == VW'(RET_CODE)));

  // R9: decoder release happens with the restored code already in place
  a_r9_release_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dec_sleep) |-> $stable(vcode_o));

  // R7: retention code lies below the bias threshold, so bias is on
  a_r7_bias_retention: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_sleep && vcode_o == VW'(RET_CODE)) |-> bias_en);
endmodule

bind dvfm_volt_ctl dvfm_volt_ctl_chk #(
  .VW(VW), .CODE_MIN(CODE_MIN), .RET_CODE(RET_CODE)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .standby_req (standby_req),
  .vcode_o     (vcode_o),
  .bias_en     (bias_en),
  .dec_sleep   (dec_sleep)
);

// File: tb/test_dvfm_volt_ctl.sv
module test_dvfm_volt_ctl;
  localparam int NT = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] taps = '0;
  logic          stby = 1'b0;
  logic [7:0]    settle = 8'd2;
  logic [5:0]    vcode;
  logic          bias, dsl;

  always #10 clk = ~clk;

  dvfm_volt_ctl i_dvfm_volt_ctl (
    .clk(clk), .rst_n(rst_n), .tap_in(taps), .standby_req(stby),
    .settle_cycles(settle), .vcode_o(vcode), .bias_en(bias), .dec_sleep(dsl)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R1";

  task automatic check(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference: 0 run, 1 settling, 2 asleep, 3 waking
  int            m_code = 63;
  int            m_mode = 0;
  int            m_wait = 0;
  logic [NT-1:0] m_cap  = '0;

  always @(posedge clk) begin
    logic [NT-1:0] seen;
    int nc;
    seen = m_cap;
    if (!rst_n) begin
      m_code = 63; m_mode = 0; m_wait = 0; m_cap = '0;
    end else begin
      m_cap = taps;
      if (m_mode == 2) begin
        if (!stby) begin m_mode = 3; m_wait = (settle == 0) ? 1 : int'(settle); end
      end else if (stby) begin
        m_mode = 2;
      end else if (m_mode == 0) begin
        nc = m_code;
        if (!(&seen[9:0])) nc = (m_code < 63) ? m_code + 1 : m_code;
        else if (&seen) nc = (m_code > 3) ? m_code - 1 : m_code;
        if (nc != m_code) begin
          m_code = nc; m_mode = 1; m_wait = (settle == 0) ? 1 : int'(settle);
        end
      end else begin
        if (m_wait <= 1) m_mode = 0;
        else m_wait--;
      end
    end
  end

  always @(negedge clk) begin
    int ec;
    string tag;
    ec  = (m_mode == 2) ? 0 : m_code;
    tag = (m_mode == 2) ? "R8" : (m_mode == 3) ? "R9" : cur_req;
    check(tag, "vcode", int'(vcode), ec);
    check(tag, "dec_sleep", int'(dsl), int'(m_mode >= 2));
    check("R7", "bias_en", int'(bias), int'(ec < 16));
  end

  function automatic logic [NT-1:0] fill(int n);
    logic [NT-1:0] f = '0;
    for (int i = 0; i < NT; i++) if (i < n) f[i] = 1'b1;
    return f;
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure_gap(output int n);
    int v = int'(vcode);
    int g = 0;
    while (int'(vcode) == v && g < 100) begin step(1); g++; end
    v = int'(vcode);
    n = 0;
    do begin step(1); n++; end while (int'(vcode) == v && n < 100);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #4000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int g, v, lf;
    step(3);
    rst_n = 1'b1;
    step(1);
    check("R1", "reset vcode", int'(vcode), 63);
    check("R1", "reset bias", int'(bias), 0);
    check("R1", "reset sleep", int'(dsl), 0);

    // descend to the floor
    cur_req = "R3"; settle = 8'd2; taps = fill(12);
    step(200);
    check("R3", "floor reached", int'(vcode), 3);
    check("R7", "bias at low code", int'(bias), 1);
    cur_req = "R6"; step(10);
    check("R6", "floor held", int'(vcode), 3);

    // climb with different settle values
    cur_req = "R2"; taps = fill(5); settle = 8'd0;
    measure_gap(g);
    check("R5", "gap settle 0", g, 2);
    settle = 8'd5;
    measure_gap(g);
    check("R5", "gap settle 5", g, 6);
    settle = 8'd9; step(2); settle = 8'd1;
    measure_gap(g);
    check("R5", "gap settle 1", g, 2);

    // hold window
    cur_req = "R4"; taps = fill(10); step(12);
    v = int'(vcode);
    step(20);
    check("R4", "hold fill10", int'(vcode), v);
    taps = fill(11); step(20);
    check("R4", "hold fill11", int'(vcode), v);
    // bubble below margin counts as a miss
    cur_req = "R2"; taps = 12'h800; settle = 8'd3; step(3);
    check("R2", "bubble raises", int'(vcode), v + 1);

    // ceiling
    cur_req = "R6"; taps = fill(0); settle = 8'd1; step(150);
    check("R6", "ceiling", int'(vcode), 63);
    check("R7", "bias off high", int'(bias), 0);

    // standby
    cur_req = "R3"; taps = fill(12); settle = 8'd3; step(21);
    v = int'(vcode);
    stby = 1'b1; step(1);
    check("R8", "retention code", int'(vcode), 0);
    check("R8", "decoder sleep", int'(dsl), 1);
    check("R7", "bias in standby", int'(bias), 1);
    taps = fill(0); step(15);
    check("R8", "frozen in standby", int'(vcode), 0);
    settle = 8'd4; stby = 1'b0;
    g = 0;
    do begin step(1); g++; end while (dsl && g < 50);
    check("R9", "sleep hold cycles", g - 1, 4);
    check("R9", "restored code", int'(vcode), v);

    // re-entry during wake-up
    cur_req = "R10"; stby = 1'b1; step(2); stby = 1'b0; step(2);
    check("R10", "waking", int'(dsl), 1);
    stby = 1'b1; step(1);
    check("R10", "back to standby", int'(vcode), 0);
    stby = 1'b0; step(10);

    // mixed traffic
    cur_req = "R2"; lf = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lf = ((lf >> 1) | ((((lf >> 0) ^ (lf >> 2) ^ (lf >> 3) ^ (lf >> 5)) & 1) << 15)) & 16'hFFFF;
      if (lf[2:0] == 3'd0) taps = NT'(lf >> 4);
      else taps = fill((lf >> 3) % 13);
      if (lf[7:4] == 4'd3) settle = 8'(lf[11:8]);
      if (lf[10:6] == 5'd7) stby = ~stby;
      step(1);
    end
    stby = 1'b0; step(20);
    summary();
  end
endmodule